// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave side of the serial command port of a small flash memory. It brings the serial clock, data-in, select and pause pins into the system clock domain through synchronisers and finds their edges there. It takes in MSB-first bytes on rising serial-clock edges and changes the serial output after falling edges, so it works when the clock idles low or idles high (SPI modes 0 and 3). The first byte of each selection is an opcode. Depending on the opcode, the block then reads a 24-bit address, sends data from a synchronous byte-read memory port with an address that counts up, sends the status byte from the write logic, or sends a two-byte identification.

The block does not make write, erase or protection decisions. It passes each program data byte to the write logic as it arrives. When the select pin goes high on a whole-byte boundary, it issues one command strobe with a code, an address and a data byte. Opcodes it does not recognise, and opcodes that arrive while the write logic is busy, make the block go quiet until the next select falling edge. A pause input freezes the bit sequencer without clearing it.

Top module: `spi_flash_front`

## Requirements
- R1: Bits are taken from `spi_si` on rising `spi_sck` edges, MSB first. `spi_so` changes only after falling `spi_sck` edges, MSB first. The first output bit follows the first falling edge after the last bit of the command header. Both clock idle levels (low and high) work.
- R2: The opcode is decoded with bit 3 ignored. The opcodes are: 0x06 write-enable, 0x04 write-disable, 0x05 status read, 0x01 status write, 0x03 read, 0x02 program, 0x52 sector erase, 0x62 chip erase, 0x15 ID read.
- R3: After any other opcode, `spi_so_oe` stays low and no strobe is issued for the rest of the selection. A new select falling edge restores normal operation.
- R4: A read takes three address bytes. Bits 23:18 are ignored. Bytes come from `mem_addr`, which counts up by one per byte and wraps from 0x3FFFF to 0x00000. `mem_rdata` is valid the cycle after `mem_rd`.
- R5: A status read sends `status_in` and repeats it for as long as clocks continue. Each byte uses the value present when that byte starts.
- R6: An ID read sends 0x1F and then 0x63.
- R7: The pause input `spi_hold_n` is taken only while `spi_sck` is low. While paused, `spi_so_oe` is low, SCK and SI are ignored, and the bit and byte positions are kept.
- R8: While `wr_busy` is high at opcode time, every opcode except status read is treated as unrecognised.
- R9: While `spi_cs_n` is high, `spi_so_oe` is low and SCK and SI have no effect.
- R10: `cmd_stb` pulses once, after a select rising edge, only if the selection ended on a byte boundary with all fields present. The codes on `cmd_code` are 1 write-enable, 2 write-disable, 4 status write (byte on `cmd_data`), 6 program, 7 sector erase and 8 chip erase. For codes 6 and 7, `cmd_addr` carries the start address.
- R11: Each program data byte pulses `pgm_byte_stb` with its address. Within a 256-byte page, the address counts up and wraps from 0xFF to 0x00.
- R12: After reset, `spi_so_oe`, `mem_rd`, `cmd_stb` and `pgm_byte_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_cs_n | input | 1 | Active-low select |
| spi_hold_n | input | 1 | Active-low pause |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so |
| wr_busy | input | 1 | Write logic busy |
| status_in | input | 8 | Status byte to send |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 18 | Memory read address |
| mem_rdata | input | 8 | Memory read data |
| pgm_byte_stb | output | 1 | Program data byte valid |
| pgm_byte_addr | output | 18 | Program byte address |
| pgm_byte_data | output | 8 | Program byte value |
| cmd_stb | output | 1 | Write command strobe |
| cmd_code | output | 4 | Write command code |
| cmd_addr | output | 18 | Command start address |
| cmd_data | output | 8 | Status write byte |

## Verification
A table of command frames covers every write-type opcode, both values of the ignored bit 3, frames that lack their data byte, and unknown codes. This separates decode errors from errors in the end-of-selection strobe logic. Reads are tried with the clock idling low and idling high, and across the top-address wrap. These runs tell apart wrong edge choice, wrong bit order and wrong counter width. Directed frames then cover a pause in the middle of a read, clocking with select high, a select that ends part-way through a byte, and opcodes that arrive while busy. Each one shows whether state was kept or ignored as the requirements say.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_WREN   = 4'd1,
    OP_WRDI   = 4'd2,
    OP_RDSR   = 4'd3,
    OP_WRSR   = 4'd4,
    OP_READ   = 4'd5,
    OP_PROG   = 4'd6,
    OP_SERASE = 4'd7,
    OP_CERASE = 4'd8,
    OP_RDID   = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_SEND,
    ST_WDATA,
    ST_SRDATA,
    ST_DONE,
    ST_DEAD
  } st_e;

  // Bit 3 of every opcode is a don't-care.
  function automatic op_e decode_op(input logic [7:0] b);
    logic [7:0] m;
    m = b & 8'hF7;
    case (m)
      8'h06:   return OP_WREN;
      8'h04:   return OP_WRDI;
      8'h05:   return OP_RDSR;
      8'h01:   return OP_WRSR;
      8'h03:   return OP_READ;
      8'h02:   return OP_PROG;
      8'h52:   return OP_SERASE;
      8'h62:   return OP_CERASE;
      8'h15:   return OP_RDID;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic takes_addr(input op_e o);
    return (o == OP_READ) || (o == OP_PROG) || (o == OP_SERASE);
  endfunction

endpackage

// File: rtl/fe_pin_sync.sv
module fe_pin_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [DEPTH-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {DEPTH{RST_VAL[g]}};
      else        chain <= {chain[DEPTH-2:0], din[g]};
    end
    assign q[g]      = chain[STAGES-1];
    assign q_prev[g] = chain[STAGES];
  end
endmodule

// File: rtl/fe_bit_engine.sv
module fe_bit_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_low,
  input  logic       cs_fall,
  input  logic       sck_lvl,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       si_lvl,
  input  logic       hold_n_lvl,
  input  logic       accept,
  input  logic       tx_en,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       bit_zero,
  output logic       tx_load,
  output logic       so_data,
  output logic       so_oe,
  output logic       hold_act
);
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, rx_q;
  logic       so_q, live_q, hold_q, done_q, load_q;
  logic       act;

  assign act = cs_low & ~hold_q & accept;

  // Pause is sampled only while the serial clock is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= 1'b0;
    else if (!sck_lvl) hold_q <= ~hold_n_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      rx_q    <= '0;
      tx_sh   <= '0;
      so_q    <= 1'b0;
      live_q  <= 1'b0;
      done_q  <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      load_q <= 1'b0;
      if (cs_fall) begin
        bit_cnt <= '0;
        live_q  <= 1'b0;
      end else if (act) begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[6:0], si_lvl};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            done_q <= 1'b1;
            rx_q   <= {rx_sh[6:0], si_lvl};
          end
        end
        if (sck_fall && tx_en) begin
          if (bit_cnt == 3'd0) begin
            so_q   <= tx_byte[7];
            tx_sh  <= {tx_byte[6:0], 1'b0};
            live_q <= 1'b1;
            load_q <= 1'b1;
          end else begin
            so_q  <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign rx_byte   = rx_q;
  assign byte_done = done_q;
  assign bit_zero  = (bit_cnt == 3'd0);
  assign tx_load   = load_q;
  assign so_data   = so_q;
  assign so_oe     = live_q & cs_low & ~hold_q & tx_en;
  assign hold_act  = hold_q;
endmodule

// File: rtl/fe_cmd_seq.sv
module fe_cmd_seq
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 8,
  parameter logic [7:0] MFR_ID = 8'h1F,
  parameter logic [7:0] DEV_ID = 8'h63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              bit_zero,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic              tx_load,
  input  logic              busy,
  input  logic [7:0]        status_in,
  input  logic [7:0]        mem_rdata,
  output logic              accept,
  output logic              tx_en,
  output logic [7:0]        tx_byte,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              byte_stb,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [7:0]        byte_data,
  output logic              cmd_stb,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);
  localparam int ABYTES = 3;
  localparam int ASH_W  = 8 * (ABYTES - 1);
  localparam logic [1:0] ALAST = 2'(ABYTES - 1);

  function automatic logic [ADDR_W-1:0] page_inc(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[PAGE_W-1:0] = a[PAGE_W-1:0] + 1'b1;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] lin_inc(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  st_e               st;
  op_e               op;
  op_e               dec;
  logic [1:0]        acnt;
  logic [ASH_W-1:0]  ash;
  logic [ADDR_W-1:0] a_next, rd_addr, wr_addr, wa_start;
  logic              fetch_pend, fetch_q, got_byte;
  logic [1:0]        id_idx;
  logic [7:0]        tx_q, sr_q;
  logic              bstb_q, cstb_q;
  logic [ADDR_W-1:0] baddr_q, caddr_q;
  logic [7:0]        bdata_q, cdata_q;
  logic [3:0]        ccode_q;
  logic              cmd_ready;

  assign dec       = decode_op(rx_byte);
  assign a_next    = ADDR_W'({ash, rx_byte});
  assign cmd_ready = bit_zero && ((st == ST_DONE) || (st == ST_WDATA && got_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OPC; op <= OP_NONE; acnt <= '0; ash <= '0;
      rd_addr <= '0; wr_addr <= '0; wa_start <= '0;
      fetch_pend <= 1'b0; fetch_q <= 1'b0; got_byte <= 1'b0;
      id_idx <= '0; tx_q <= '0; sr_q <= '0;
      bstb_q <= 1'b0; cstb_q <= 1'b0; baddr_q <= '0; caddr_q <= '0;
      bdata_q <= '0; cdata_q <= '0; ccode_q <= '0;
    end else begin
      fetch_pend <= 1'b0;
      fetch_q    <= fetch_pend;
      bstb_q     <= 1'b0;
      cstb_q     <= 1'b0;
      if (st == ST_SEND && op == OP_RDSR) tx_q <= status_in;
      else if (fetch_q)                   tx_q <= mem_rdata;
      if (cs_fall) begin
        st <= ST_OPC; op <= OP_NONE; acnt <= '0;
        got_byte <= 1'b0; id_idx <= '0;
      end else begin
        if (cs_rise && cmd_ready) begin
          cstb_q  <= 1'b1;
          ccode_q <= op;
          caddr_q <= wa_start;
          cdata_q <= sr_q;
        end
        if (byte_done) begin
          case (st)
            ST_OPC: begin
              op <= dec;
              if (dec == OP_NONE || (busy && dec != OP_RDSR)) st <= ST_DEAD;
              else if (takes_addr(dec)) begin
                st <= ST_ADDR; acnt <= '0;
              end else if (dec == OP_RDSR) begin
                st <= ST_SEND; tx_q <= status_in;
              end else if (dec == OP_RDID) begin
                st <= ST_SEND; tx_q <= MFR_ID; id_idx <= 2'd1;
              end else if (dec == OP_WRSR) st <= ST_SRDATA;
              else st <= ST_DONE;
            end
            ST_ADDR: begin
              ash  <= {ash[ASH_W-9:0], rx_byte};
              acnt <= acnt + 2'd1;
              if (acnt == ALAST) begin
                if (op == OP_READ) begin
                  st <= ST_SEND; rd_addr <= a_next; fetch_pend <= 1'b1;
                end else begin
                  st <= (op == OP_PROG) ? ST_WDATA : ST_DONE;
                  wr_addr  <= a_next;
                  wa_start <= a_next;
                end
              end
            end
            ST_WDATA: begin
              bstb_q   <= 1'b1;
              baddr_q  <= wr_addr;
              bdata_q  <= rx_byte;
              wr_addr  <= page_inc(wr_addr);
              got_byte <= 1'b1;
            end
            ST_SRDATA: begin
              sr_q <= rx_byte;
              st   <= ST_DONE;
            end
            default: ;
          endcase
        end
        if (tx_load && st == ST_SEND) begin
          if (op == OP_READ) begin
            rd_addr    <= lin_inc(rd_addr);
            fetch_pend <= 1'b1;
          end else if (op == OP_RDID) begin
            tx_q   <= (id_idx == 2'd1) ? DEV_ID : 8'h00;
            id_idx <= 2'd2;
          end
        end
      end
    end
  end

  assign accept    = (st != ST_DEAD);
  assign tx_en     = (st == ST_SEND);
  assign tx_byte   = tx_q;
  assign mem_rd    = fetch_pend;
  assign mem_addr  = rd_addr;
  assign byte_stb  = bstb_q;
  assign byte_addr = baddr_q;
  assign byte_data = bdata_q;
  assign cmd_stb   = cstb_q;
  assign cmd_code  = ccode_q;
  assign cmd_addr  = caddr_q;
  assign cmd_data  = cdata_q;
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int ADDR_W = 18,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] MFR_ID = 8'h1F,
  parameter logic [7:0] DEV_ID = 8'h63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_si,
  input  logic              spi_cs_n,
  input  logic              spi_hold_n,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              wr_busy,
  input  logic [7:0]        status_in,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pgm_byte_stb,
  output logic [ADDR_W-1:0] pgm_byte_addr,
  output logic [7:0]        pgm_byte_data,
  output logic              cmd_stb,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);
  localparam int NPIN  = 4;
  localparam int P_SCK = 0;
  localparam int P_SI  = 1;
  localparam int P_CS  = 2;
  localparam int P_HLD = 3;

  logic [NPIN-1:0] pin_q, pin_prev;
  logic sck_rise, sck_fall, cs_low, cs_fall, cs_rise;
  logic [7:0] rx_byte, tx_byte;
  logic byte_done, bit_zero, tx_load, accept, tx_en, hold_act;

  fe_pin_sync #(.N(NPIN), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({spi_hold_n, spi_cs_n, spi_si, spi_sck}),
    .q(pin_q), .q_prev(pin_prev)
  );

  assign sck_rise = pin_q[P_SCK] & ~pin_prev[P_SCK];
  assign sck_fall = ~pin_q[P_SCK] & pin_prev[P_SCK];
  assign cs_low   = ~pin_q[P_CS];
  assign cs_fall  = ~pin_q[P_CS] & pin_prev[P_CS];
  assign cs_rise  = pin_q[P_CS] & ~pin_prev[P_CS];

  fe_bit_engine u_bits (
    .clk(clk), .rst_n(rst_n),
    .cs_low(cs_low), .cs_fall(cs_fall),
    .sck_lvl(pin_q[P_SCK]), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_lvl(pin_q[P_SI]), .hold_n_lvl(pin_q[P_HLD]),
    .accept(accept), .tx_en(tx_en), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .byte_done(byte_done), .bit_zero(bit_zero),
    .tx_load(tx_load), .so_data(spi_so), .so_oe(spi_so_oe),
    .hold_act(hold_act)
  );

  fe_cmd_seq #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .bit_zero(bit_zero),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_load(tx_load),
    .busy(wr_busy), .status_in(status_in), .mem_rdata(mem_rdata),
    .accept(accept), .tx_en(tx_en), .tx_byte(tx_byte),
    .mem_rd(mem_rd), .mem_addr(mem_addr),
    .byte_stb(pgm_byte_stb), .byte_addr(pgm_byte_addr), .byte_data(pgm_byte_data),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );
endmodule

// File: rtl/fe_checker.sv
module fe_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_low,
  input logic cs_rise,
  input logic hold_act,
  input logic accept,
  input logic sck_fall,
  input logic so_oe,
  input logic so_data,
  input logic cmd_stb,
  input logic mem_rd
);
  p_oe_needs_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |-> !so_oe);

  p_oe_off_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !so_oe);

  p_silent_after_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> !so_oe);

  p_no_cmd_when_dead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && cs_low) |=> !cmd_stb);

  p_cmd_follows_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(cs_rise));

  p_so_moves_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so_data));

  p_memrd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

bind spi_flash_front fe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_rise(cs_rise),
  .hold_act(hold_act), .accept(accept), .sck_fall(sck_fall),
  .so_oe(spi_so_oe), .so_data(spi_so), .cmd_stb(cmd_stb), .mem_rd(mem_rd)
);

// File: tb/sim_spi_flash_front.sv
module sim_spi_flash_front;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
  logic so, so_oe, busy = 1'b0;
  logic [7:0] status = 8'hA6;
  logic mem_rd;
  logic [17:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic pb_stb, c_stb;
  logic [17:0] pb_addr, c_addr;
  logic [7:0] pb_data, c_data;
  logic [3:0] c_code;

  int checks = 0, errors = 0;
  bit mode3 = 1'b0;
  int n_cmd = 0, n_pb = 0, n_memrd = 0;
  logic [3:0] l_code;
  logic [17:0] l_addr;
  logic [7:0] l_data;
  logic [17:0] pba [4];
  logic [7:0] pbd [4];
  bit oe_any, oe_gap;

  always #10 clk = ~clk;

  spi_flash_front u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_si(si), .spi_cs_n(cs_n),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe), .wr_busy(busy),
    .status_in(status), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pgm_byte_stb(pb_stb), .pgm_byte_addr(pb_addr), .pgm_byte_data(pb_data),
    .cmd_stb(c_stb), .cmd_code(c_code), .cmd_addr(c_addr), .cmd_data(c_data)
  );

  function automatic logic [7:0] mpat(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mpat(mem_addr);
      n_memrd++;
    end
    if (c_stb) begin
      n_cmd++; l_code = c_code; l_addr = c_addr; l_data = c_data;
    end
    if (pb_stb) begin
      if (n_pb < 4) begin pba[n_pb] = pb_addr; pbd[n_pb] = pb_data; end
      n_pb++;
    end
  end

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    report();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic half;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_begin;
    sck = mode3;
    half();
    cs_n = 1'b0;
    half();
    oe_any = 1'b0; oe_gap = 1'b0;
  endtask

  task automatic cs_end;
    half();
    cs_n = 1'b1;
    repeat (3) half();
  endtask

  task automatic xbit(input logic b, output logic r);
    if (mode3) sck = 1'b0;
    si = b;
    half();
    r = so;
    if (so_oe) oe_any = 1'b1; else oe_gap = 1'b1;
    sck = 1'b1;
    half();
    if (!mode3) sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xbit(b[i], r[i]);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xbyte(a[23:16], d); xbyte(a[15:8], d); xbyte(a[7:0], d);
  endtask

  // Command frame table: opcode, address, data, has_addr, has_data, exp strobe, exp code
  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [7:0]  data;
    logic        ha;
    logic        hd;
    logic        stb;
    logic [3:0]  code;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'h06, 24'h000000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd1},
    '{8'h0E, 24'h000000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd1},
    '{8'h04, 24'h000000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd2},
    '{8'h0C, 24'h000000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd2},
    '{8'h01, 24'h000000, 8'h8C, 1'b0, 1'b1, 1'b1, 4'd4},
    '{8'h01, 24'h000000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0},
    '{8'h02, 24'hFC0123, 8'h5A, 1'b1, 1'b1, 1'b1, 4'd6},
    '{8'h02, 24'h000040, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0},
    '{8'h52, 24'h025555, 8'h00, 1'b1, 1'b0, 1'b1, 4'd7},
    '{8'h5A, 24'h030000, 8'h00, 1'b1, 1'b0, 1'b1, 4'd7},
    '{8'h62, 24'h000000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd8},
    '{8'h07, 24'h000000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0},
    '{8'h16, 24'h000000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0}
  };

  initial begin
    logic [7:0] r;
    logic b;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 so_oe in reset", so_oe, 0);
    chk("R12 mem_rd in reset", mem_rd, 0);
    chk("R12 cmd_stb in reset", c_stb, 0);
    chk("R12 pgm_byte_stb in reset", pb_stb, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2 / R10 table walk
    for (int k = 0; k < NV; k++) begin
      n_cmd = 0;
      mode3 = k[0];
      cs_begin();
      xbyte(VEC[k].op, r);
      if (VEC[k].ha) send_addr(VEC[k].addr);
      if (VEC[k].hd) xbyte(VEC[k].data, r);
      cs_end();
      chk($sformatf("R2/R10 vec %0d strobe count", k), n_cmd, {31'd0, VEC[k].stb});
      if (VEC[k].stb) begin
        chk($sformatf("R2/R10 vec %0d code", k), l_code, VEC[k].code);
        if (VEC[k].ha) chk($sformatf("R10 vec %0d addr", k), l_addr, VEC[k].addr[17:0]);
        if (VEC[k].code == 4'd4) chk($sformatf("R10 vec %0d data", k), l_data, VEC[k].data);
      end
    end
    mode3 = 1'b0;

    // R5 status read, repeated, tracks input per byte
    cs_begin(); xbyte(8'h05, r);
    xbyte(8'h00, r); chk("R5 status byte 1", r, 8'hA6);
    status = 8'h5B;
    xbyte(8'h00, r); chk("R5 status byte 2", r, 8'h5B);
    cs_end();

    // R6 identification, with bit 3 set in the opcode
    cs_begin(); xbyte(8'h1D, r);
    xbyte(8'h00, r); chk("R6 id byte 1", r, 8'h1F);
    xbyte(8'h00, r); chk("R6 id byte 2", r, 8'h63);
    cs_end();

    // R4 / R1 read, clock idles low, upper address bits ignored
    cs_begin(); xbyte(8'h03, r); send_addr(24'hAC1234);
    oe_gap = 1'b0;
    for (int i = 0; i < 3; i++) begin
      xbyte(8'hFF, r);
      chk("R4 R1 mode0 read byte", r, mpat(18'h01234 + 18'(i)));
    end
    chk("R1 output enabled through data", oe_gap, 0);
    cs_end();

    // R4 / R1 read, clock idles high, wrap at top address
    mode3 = 1'b1;
    cs_begin(); xbyte(8'h03, r); send_addr(24'h03FFFE);
    xbyte(8'h00, r); chk("R4 R1 mode3 byte at 3FFFE", r, mpat(18'h3FFFE));
    xbyte(8'h00, r); chk("R4 mode3 byte at 3FFFF", r, mpat(18'h3FFFF));
    xbyte(8'h00, r); chk("R4 wrap to 00000", r, mpat(18'h00000));
    cs_end();
    mode3 = 1'b0;

    // R7 pause in the middle of a read
    cs_begin(); xbyte(8'h03, r); send_addr(24'h000100);
    xbyte(8'h00, r); chk("R7 byte before pause", r, mpat(18'h00100));
    hold_n = 1'b0;
    half();
    chk("R7 output off while paused", so_oe, 0);
    for (int i = 0; i < 4; i++) begin
      si = i[0]; sck = 1'b1; half(); chk("R7 output off with clocks", so_oe, 0);
      sck = 1'b0; half();
    end
    hold_n = 1'b1;
    half();
    xbyte(8'h00, r); chk("R7 byte after pause keeps position", r, mpat(18'h00101));
    cs_end();

    // R3 unrecognised opcode silences the rest of the selection
    n_cmd = 0;
    cs_begin(); xbyte(8'h07, r);
    oe_any = 1'b0;
    xbyte(8'h06, r); xbyte(8'h15, r); xbyte(8'h00, r);
    cs_end();
    chk("R3 no output after bad opcode", oe_any, 0);
    chk("R3 no strobe after bad opcode", n_cmd, 0);
    cs_begin(); xbyte(8'h15, r); xbyte(8'h00, r);
    chk("R3 recovers on next select", r, 8'h1F);
    cs_end();

    // R8 busy write logic
    busy = 1'b1; n_cmd = 0;
    cs_begin(); xbyte(8'h06, r); cs_end();
    chk("R8 write enable ignored while busy", n_cmd, 0);
    cs_begin(); xbyte(8'h03, r); oe_any = 1'b0; send_addr(24'h0); xbyte(8'h00, r); cs_end();
    chk("R8 read ignored while busy", oe_any, 0);
    cs_begin(); xbyte(8'h05, r); xbyte(8'h00, r); cs_end();
    chk("R8 status read allowed while busy", r, 8'h5B);
    busy = 1'b0;

    // R9 clocks with select high have no effect
    n_cmd = 0; n_memrd = 0; oe_any = 1'b0;
    for (int i = 0; i < 13; i++) begin
      si = i[1]; sck = 1'b1; half(); if (so_oe) oe_any = 1'b1;
      sck = 1'b0; half(); if (so_oe) oe_any = 1'b1;
    end
    chk("R9 output off while deselected", oe_any, 0);
    chk("R9 no strobe while deselected", n_cmd, 0);
    chk("R9 no memory read while deselected", n_memrd, 0);
    cs_begin(); xbyte(8'h15, r); xbyte(8'h00, r);
    chk("R9 bit position unaffected", r, 8'h1F);
    cs_end();

    // R10 selection ending inside a byte
    n_cmd = 0;
    cs_begin(); xbyte(8'h06, r);
    xbit(1'b0, b); xbit(1'b1, b); xbit(1'b0, b);
    cs_end();
    chk("R10 partial byte gives no strobe", n_cmd, 0);

    // R11 program bytes wrap inside the page
    n_cmd = 0; n_pb = 0;
    cs_begin(); xbyte(8'h02, r); send_addr(24'h0012FE);
    xbyte(8'h11, r); xbyte(8'h22, r); xbyte(8'h33, r);
    cs_end();
    chk("R11 data byte count", n_pb, 3);
    chk("R11 first byte addr", pba[0], 18'h012FE);
    chk("R11 second byte addr", pba[1], 18'h012FF);
    chk("R11 third byte wraps in page", pba[2], 18'h01200);
    chk("R11 third byte value", pbd[2], 8'h33);
    chk("R10 program strobe start addr", l_addr, 18'h012FE);
    chk("R10 program strobe code", l_code, 4'd6);

    report();
  end
endmodule